// File: doc/BRIEF.md
# SPI Host Register and FIFO Front End

This block is the software-facing half of an SPI host. It decodes a simple 32-bit register bus and holds the serial configuration: clock divider, clock mode, chip-select selection, default and mode, two delay words and the frame format. The configuration is exported unchanged to a separate shift engine, which produces the serial clock and the line timing.

The block also holds an 8-entry transmit byte queue and an 8-entry receive byte queue. Software writes bytes into the transmit queue. The engine takes them one at a time through a valid/ready handshake, and it returns each received byte with a one-cycle done strobe. The data registers report the queue status in bit 31. Two watermark comparisons drive a single level interrupt.

Configuration writes that fall outside the legal range are dropped without any error report. Offsets that are not mapped behave as empty space.

Top module: `spi_regfront`

## Requirements
- R1: After reset, the divider reads 0x3, the first delay word reads 0x1001, the second delay word reads 0x1, the chip-select default reads all ones over the NUM_CS implemented selects, every other register reads 0, and both queues are empty.
- R2: A write to TX data (offset 0x48) pushes bits 7:0 into the transmit queue, and the write is dropped when the queue already holds 8 bytes. `tx_valid_o` is high while the queue is not empty, `tx_byte_o` is the oldest byte, and a cycle with `tx_valid_o` and `tx_ready_i` both high removes that byte.
- R3: A read of TX data returns 0x8000_0000 when the transmit queue is full and 0 otherwise.
- R4: A read of RX data (offset 0x4C) returns 0x8000_0000 when the receive queue is empty. Otherwise it removes the oldest byte and returns it in bits 7:0, with bit 31 clear.
- R5: A byte presented with `rx_done_i` enters the receive queue on the following cycle. It is discarded instead when bit 3 of the frame format register (offset 0x40) is set, or when the receive queue is full at that moment.
- R6: Interrupt pending (offset 0x74) bit 0 is set while the transmit count is below the TX watermark (0x50). Bit 1 is set while the receive count is above the RX watermark (0x54). Both bits follow the counts in the same cycle.
- R7: `irq_o` is high exactly when some pending bit is set together with the matching bit of the interrupt enable register (0x70).
- R8: A write of 8 or more to either watermark register is ignored, and the old value is kept.
- R9: A chip-select id write (0x10) with a value of NUM_CS or more is ignored. A chip-select default write (0x14) with a value of 2^NUM_CS or more is ignored. A chip-select mode write (0x18) above 3 is ignored.
- R10: Unmapped and reserved offsets read 0 and ignore writes. Writes to RX data and to interrupt pending have no effect.
- R11: Divider (0x00), clock mode (0x04), both delay words (0x28, 0x2C), frame format and interrupt enable store the full 32-bit write value. They read it back and drive it on the matching configuration outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Bus access strobe |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | AW | Byte address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid in the cycle of a read; 0 otherwise |
| tx_valid_o | output | 1 | Transmit byte available |
| tx_byte_o | output | 8 | Oldest transmit byte |
| tx_ready_i | input | 1 | Engine accepts the transmit byte |
| rx_done_i | input | 1 | Engine finished a byte |
| rx_byte_i | input | 8 | Received byte, valid with rx_done_i |
| sck_div_o | output | 32 | Clock divider value |
| sck_mode_o | output | 32 | Clock mode value |
| cs_id_o | output | CSW | Selected chip select |
| cs_def_o | output | NUM_CS | Chip-select default levels |
| cs_mode_o | output | 2 | Chip-select mode |
| dly0_o | output | 32 | First delay word |
| dly1_o | output | 32 | Second delay word |
| fmt_o | output | 32 | Frame format word |
| irq_o | output | 1 | Watermark interrupt |

## Verification
The hardest cases to reach are the ones where bus traffic and engine traffic land on the same cycle. Examples are a bus pop of a full receive queue in the cycle its delayed byte arrives, and a transmit push into a full queue while the engine removes the head. The stimulus first fills both queues by stalling `tx_ready_i` and pulsing `rx_done_i` without reading. It then issues reads and writes at the exact offsets of the delayed return. A behavioural queue model, advanced on the same edges, predicts every output on every cycle.

// File: rtl/spi_regfront_pkg.sv
package spi_regfront_pkg;
  localparam int unsigned DW = 32;
  // word index = byte offset >> 2
  localparam logic [5:0] W_DIV    = 6'h00;
  localparam logic [5:0] W_MODE   = 6'h01;
  localparam logic [5:0] W_CSID   = 6'h04;
  localparam logic [5:0] W_CSDEF  = 6'h05;
  localparam logic [5:0] W_CSMODE = 6'h06;
  localparam logic [5:0] W_DLY0   = 6'h0A;
  localparam logic [5:0] W_DLY1   = 6'h0B;
  localparam logic [5:0] W_FMT    = 6'h10;
  localparam logic [5:0] W_TXD    = 6'h12;
  localparam logic [5:0] W_RXD    = 6'h13;
  localparam logic [5:0] W_TXM    = 6'h14;
  localparam logic [5:0] W_RXM    = 6'h15;
  localparam logic [5:0] W_IE     = 6'h1C;
  localparam logic [5:0] W_IP     = 6'h1D;

  localparam logic [DW-1:0] STAT_BIT  = 32'h8000_0000;
  localparam logic [DW-1:0] DIV_RST   = 32'h0000_0003;
  localparam logic [DW-1:0] DLY0_RST  = 32'h0000_1001;
  localparam logic [DW-1:0] DLY1_RST  = 32'h0000_0001;
  localparam int unsigned   FMT_NORX  = 3;
endpackage

// File: rtl/spi_byte_fifo.sv
module spi_byte_fifo #(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned BW    = 8,
  localparam int unsigned PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic [BW-1:0] din_i,
  input  logic          pop_i,
  output logic [BW-1:0] head_o,
  output logic [CW-1:0] cnt_o,
  output logic          full_o,
  output logic          empty_o
);
  logic [BW-1:0] mem_q [DEPTH];
  logic [PW-1:0] wptr_q, rptr_q;
  logic [CW-1:0] cnt_q;
  logic          do_push, do_pop;

  assign full_o  = (cnt_q == CW'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign do_push = push_i && !full_o;
  assign do_pop  = pop_i && !empty_o;
  assign head_o  = mem_q[rptr_q];
  assign cnt_o   = cnt_q;

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (do_push) wptr_q <= nxt(wptr_q);
      if (do_pop)  rptr_q <= nxt(rptr_q);
      cnt_q <= cnt_q + CW'(do_push) - CW'(do_pop);
    end
  end

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wptr_q] <= din_i;
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CW'(DEPTH)); // R2
  AST_FULL_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && !pop_i && full_o) |=> (cnt_q == CW'(DEPTH))); // R2
endmodule

// File: rtl/spi_cfg_regs.sv
module spi_cfg_regs
  import spi_regfront_pkg::*;
#(
  parameter int unsigned NUM_CS = 1,
  parameter int unsigned DEPTH  = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic [5:0]    word_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] div_o,
  output logic [DW-1:0] mode_o,
  output logic [DW-1:0] csid_o,
  output logic [DW-1:0] csdef_o,
  output logic [DW-1:0] csmode_o,
  output logic [DW-1:0] dly0_o,
  output logic [DW-1:0] dly1_o,
  output logic [DW-1:0] fmt_o,
  output logic [DW-1:0] txm_o,
  output logic [DW-1:0] rxm_o,
  output logic [DW-1:0] ie_o
);
  localparam logic [DW-1:0] CS_LIM  = DW'(NUM_CS);
  localparam logic [DW-1:0] DEF_LIM = DW'(1) << NUM_CS;
  localparam logic [DW-1:0] DEF_RST = DEF_LIM - 1;
  localparam logic [DW-1:0] WM_LIM  = DW'(DEPTH);

  logic [DW-1:0] div_q, mode_q, csid_q, csdef_q, csmode_q;
  logic [DW-1:0] dly0_q, dly1_q, fmt_q, txm_q, rxm_q, ie_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q    <= DIV_RST;
      mode_q   <= '0;
      csid_q   <= '0;
      csdef_q  <= DEF_RST;
      csmode_q <= '0;
      dly0_q   <= DLY0_RST;
      dly1_q   <= DLY1_RST;
      fmt_q    <= '0;
      txm_q    <= '0;
      rxm_q    <= '0;
      ie_q     <= '0;
    end else if (wr_i) begin
      unique case (word_i)
        W_DIV:    div_q  <= wdata_i;
        W_MODE:   mode_q <= wdata_i;
        W_DLY0:   dly0_q <= wdata_i;
        W_DLY1:   dly1_q <= wdata_i;
        W_FMT:    fmt_q  <= wdata_i;
        W_IE:     ie_q   <= wdata_i;
        W_CSID:   if (wdata_i < CS_LIM)  csid_q   <= wdata_i;
        W_CSDEF:  if (wdata_i < DEF_LIM) csdef_q  <= wdata_i;
        W_CSMODE: if (wdata_i <= 32'd3)  csmode_q <= wdata_i;
        W_TXM:    if (wdata_i < WM_LIM)  txm_q    <= wdata_i;
        W_RXM:    if (wdata_i < WM_LIM)  rxm_q    <= wdata_i;
        default: ;
      endcase
    end
  end

  assign div_o    = div_q;
  assign mode_o   = mode_q;
  assign csid_o   = csid_q;
  assign csdef_o  = csdef_q;
  assign csmode_o = csmode_q;
  assign dly0_o   = dly0_q;
  assign dly1_o   = dly1_q;
  assign fmt_o    = fmt_q;
  assign txm_o    = txm_q;
  assign rxm_o    = rxm_q;
  assign ie_o     = ie_q;

  AST_MARK_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (txm_q < WM_LIM) && (rxm_q < WM_LIM)); // R8
  AST_CSID_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    csid_q < CS_LIM); // R9
  AST_CSDEF_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    csdef_q < DEF_LIM); // R9
  AST_CSMODE_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    csmode_q <= 32'd3); // R9
  AST_MARK_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && word_i == W_TXM && wdata_i >= WM_LIM) |=> $stable(txm_q)); // R8
endmodule

// File: rtl/spi_wm_irq.sv
module spi_wm_irq #(
  parameter int unsigned DEPTH = 8,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [CW-1:0] tx_cnt_i,
  input  logic [CW-1:0] rx_cnt_i,
  input  logic [31:0]   txm_i,
  input  logic [31:0]   rxm_i,
  input  logic [1:0]    ie_i,
  output logic [1:0]    ip_o,
  output logic          irq_o
);
  assign ip_o[0] = 32'(tx_cnt_i) < txm_i;
  assign ip_o[1] = 32'(rx_cnt_i) > rxm_i;
  assign irq_o   = |(ip_o & ie_i);

  AST_TX_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_cnt_i == '0 && txm_i != '0) |-> ip_o[0]); // R6
  AST_RX_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_cnt_i == CW'(DEPTH) && txm_i < 32'(DEPTH)) |-> ip_o[1] || rxm_i >= 32'(DEPTH)); // R6
endmodule

// File: rtl/spi_regfront.sv
module spi_regfront
  import spi_regfront_pkg::*;
#(
  parameter int unsigned NUM_CS = 1,
  parameter int unsigned AW     = 12,
  parameter int unsigned DEPTH  = 8,
  localparam int unsigned CSW   = (NUM_CS > 1) ? $clog2(NUM_CS) : 1,
  localparam int unsigned CW    = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [AW-1:0]     addr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  output logic              tx_valid_o,
  output logic [7:0]        tx_byte_o,
  input  logic              tx_ready_i,
  input  logic              rx_done_i,
  input  logic [7:0]        rx_byte_i,
  output logic [31:0]       sck_div_o,
  output logic [31:0]       sck_mode_o,
  output logic [CSW-1:0]    cs_id_o,
  output logic [NUM_CS-1:0] cs_def_o,
  output logic [1:0]        cs_mode_o,
  output logic [31:0]       dly0_o,
  output logic [31:0]       dly1_o,
  output logic [31:0]       fmt_o,
  output logic              irq_o
);
  logic [5:0]  word;
  logic        in_map, wr, rd;
  logic [31:0] csid, csdef, csmode, fmt, txm, rxm, ie;
  logic [7:0]  tx_head, rx_head;
  logic [CW-1:0] tx_cnt, rx_cnt;
  logic        tx_full, tx_empty, rx_full, rx_empty;
  logic        tx_push, tx_pop, rx_push, rx_pop;
  logic        ret_v_q;
  logic [7:0]  ret_b_q;
  logic [1:0]  ip;
  logic [31:0] rmux;

  assign word   = addr_i[7:2];
  assign in_map = (addr_i[AW-1:8] == '0);
  assign wr     = req_i && we_i && in_map;
  assign rd     = req_i && !we_i && in_map;

  spi_cfg_regs #(.NUM_CS(NUM_CS), .DEPTH(DEPTH)) u_cfg (
    .clk_i, .rst_ni, .wr_i(wr), .word_i(word), .wdata_i,
    .div_o(sck_div_o), .mode_o(sck_mode_o), .csid_o(csid), .csdef_o(csdef),
    .csmode_o(csmode), .dly0_o, .dly1_o, .fmt_o(fmt), .txm_o(txm),
    .rxm_o(rxm), .ie_o(ie)
  );

  assign cs_id_o   = csid[CSW-1:0];
  assign cs_def_o  = csdef[NUM_CS-1:0];
  assign cs_mode_o = csmode[1:0];
  assign fmt_o     = fmt;

  // transmit side
  assign tx_push    = wr && (word == W_TXD);
  assign tx_valid_o = !tx_empty;
  assign tx_byte_o  = tx_head;
  assign tx_pop     = tx_valid_o && tx_ready_i;

  spi_byte_fifo #(.DEPTH(DEPTH), .BW(8)) u_txq (
    .clk_i, .rst_ni, .push_i(tx_push), .din_i(wdata_i[7:0]), .pop_i(tx_pop),
    .head_o(tx_head), .cnt_o(tx_cnt), .full_o(tx_full), .empty_o(tx_empty)
  );

  // receive side: one stage between engine strobe and queue
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ret_v_q <= 1'b0;
      ret_b_q <= '0;
    end else begin
      ret_v_q <= rx_done_i;
      if (rx_done_i) ret_b_q <= rx_byte_i;
    end
  end

  assign rx_push = ret_v_q && !fmt[FMT_NORX];
  assign rx_pop  = rd && (word == W_RXD);

  spi_byte_fifo #(.DEPTH(DEPTH), .BW(8)) u_rxq (
    .clk_i, .rst_ni, .push_i(rx_push), .din_i(ret_b_q), .pop_i(rx_pop),
    .head_o(rx_head), .cnt_o(rx_cnt), .full_o(rx_full), .empty_o(rx_empty)
  );

  spi_wm_irq #(.DEPTH(DEPTH)) u_irq (
    .clk_i, .rst_ni, .tx_cnt_i(tx_cnt), .rx_cnt_i(rx_cnt),
    .txm_i(txm), .rxm_i(rxm), .ie_i(ie[1:0]), .ip_o(ip), .irq_o
  );

  always_comb begin
    unique case (word)
      W_DIV:    rmux = sck_div_o;
      W_MODE:   rmux = sck_mode_o;
      W_CSID:   rmux = csid;
      W_CSDEF:  rmux = csdef;
      W_CSMODE: rmux = csmode;
      W_DLY0:   rmux = dly0_o;
      W_DLY1:   rmux = dly1_o;
      W_FMT:    rmux = fmt;
      W_TXD:    rmux = tx_full ? STAT_BIT : '0;
      W_RXD:    rmux = rx_empty ? STAT_BIT : {24'h0, rx_head};
      W_TXM:    rmux = txm;
      W_RXM:    rmux = rxm;
      W_IE:     rmux = ie;
      W_IP:     rmux = {30'h0, ip};
      default:  rmux = '0;
    endcase
  end

  assign rdata_o = rd ? rmux : '0;

  AST_RX_EMPTY_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_pop && rx_empty) |-> (rdata_o == STAT_BIT)); // R4
  AST_RX_DISCARD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ret_v_q && fmt[FMT_NORX] && !rx_pop) |=> $stable(rx_cnt)); // R5
  AST_TX_HEAD_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_valid_o && !tx_ready_i) |=> tx_valid_o); // R2
  AST_UNMAPPED_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && !in_map) |-> (rdata_o == '0)); // R10
endmodule

// File: tb/tb_spi_regfront.sv
module tb_spi_regfront;
  localparam int NCS = 2;
  localparam int AW  = 12;

  logic clk = 0, rst_n = 0;
  logic req = 0, we = 0, txr = 0, rxd = 0;
  logic [AW-1:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [7:0] rxb = '0;
  logic [31:0] rdata, div_o, mode_o, d0_o, d1_o, fmt_o;
  logic tx_valid, irq;
  logic [7:0] tx_byte;
  logic [0:0] csid_o;
  logic [1:0] csdef_o, csmode_o;

  int n_chk = 0, n_bad = 0;

  always #4 clk = ~clk;

  spi_regfront #(.NUM_CS(NCS), .AW(AW), .DEPTH(8)) dut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .tx_valid_o(tx_valid), .tx_byte_o(tx_byte),
    .tx_ready_i(txr), .rx_done_i(rxd), .rx_byte_i(rxb), .sck_div_o(div_o),
    .sck_mode_o(mode_o), .cs_id_o(csid_o), .cs_def_o(csdef_o), .cs_mode_o(csmode_o),
    .dly0_o(d0_o), .dly1_o(d1_o), .fmt_o(fmt_o), .irq_o(irq)
  );

  // reference model
  byte unsigned txq[$], rxq[$];
  logic [31:0] m_div, m_mode, m_csid, m_csdef, m_csmode, m_d0, m_d1, m_fmt, m_txm, m_rxm, m_ie;
  bit m_pv; byte unsigned m_pb;
  bit in_reset_phase;

  task automatic model_reset();
    txq.delete(); rxq.delete();
    m_div = 3; m_mode = 0; m_csid = 0; m_csdef = (1 << NCS) - 1; m_csmode = 0;
    m_d0 = 32'h1001; m_d1 = 1; m_fmt = 0; m_txm = 0; m_rxm = 0; m_ie = 0;
    m_pv = 0; m_pb = 0;
  endtask

  function automatic logic [1:0] m_ip();
    return {(rxq.size() > int'(m_rxm)), (txq.size() < int'(m_txm))};
  endfunction

  function automatic logic [31:0] m_read(input int w);
    case (w)
      'h00: return m_div;   'h01: return m_mode;
      'h04: return m_csid;  'h05: return m_csdef;  'h06: return m_csmode;
      'h0A: return m_d0;    'h0B: return m_d1;     'h10: return m_fmt;
      'h12: return (txq.size() == 8) ? 32'h8000_0000 : 32'h0;
      'h13: return (rxq.size() == 0) ? 32'h8000_0000 : {24'h0, rxq[0]};
      'h14: return m_txm;   'h15: return m_rxm;
      'h1C: return m_ie;    'h1D: return {30'h0, m_ip()};
      default: return 0;
    endcase
  endfunction

  function automatic string tag_of(input int w);
    if (in_reset_phase) return "R1";
    case (w)
      'h12: return "R3";
      'h13: return "R4/R5";
      'h1D: return "R6";
      'h14, 'h15: return "R8";
      'h04, 'h05, 'h06: return "R9";
      'h00, 'h01, 'h0A, 'h0B, 'h10, 'h1C: return "R11";
      default: return "R10";
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h at %0t", tag, act, exp, $time);
    end
  endtask

  // compare pre-edge outputs, then advance the model across the edge
  task automatic step();
    int w;
    bit mapped, txp, rxp;
    #1;
    w = int'(addr[7:2]);
    mapped = (addr[AW-1:8] == 0);
    chk((req && !we) ? tag_of(w) : "R10", rdata, (req && !we && mapped) ? m_read(w) : 32'h0);
    chk("R2", {31'h0, tx_valid}, {31'h0, txq.size() > 0});
    if (txq.size() > 0) chk("R2", {24'h0, tx_byte}, {24'h0, txq[0]});
    chk("R6/R7", {31'h0, irq}, {31'h0, |(m_ip() & m_ie[1:0])});
    chk("R11", div_o, m_div);
    chk("R11", mode_o, m_mode);
    chk("R11", d0_o, m_d0);
    chk("R11", d1_o, m_d1);
    chk("R11", fmt_o, m_fmt);
    chk("R9", {31'h0, csid_o}, {31'h0, m_csid[0]});
    chk("R9", {30'h0, csdef_o}, {30'h0, m_csdef[1:0]});
    chk("R9", {30'h0, csmode_o}, {30'h0, m_csmode[1:0]});
    // updates, decided on pre-edge state
    txp = req && we && mapped && w == 'h12 && txq.size() < 8;
    rxp = m_pv && !m_fmt[3] && rxq.size() < 8;
    if (tx_valid && txr) void'(txq.pop_front());
    if (txp) txq.push_back(wdata[7:0]);
    if (req && !we && mapped && w == 'h13 && rxq.size() > 0) void'(rxq.pop_front());
    if (rxp) rxq.push_back(m_pb);
    m_pv = rxd;
    if (rxd) m_pb = rxb;
    if (req && we && mapped) begin
      case (w)
        'h00: m_div = wdata;  'h01: m_mode = wdata;
        'h0A: m_d0 = wdata;   'h0B: m_d1 = wdata;
        'h10: m_fmt = wdata;  'h1C: m_ie = wdata;
        'h04: if (wdata < NCS) m_csid = wdata;
        'h05: if (wdata < (1 << NCS)) m_csdef = wdata;
        'h06: if (wdata <= 3) m_csmode = wdata;
        'h14: if (wdata < 8) m_txm = wdata;
        'h15: if (wdata < 8) m_rxm = wdata;
        default: ;
      endcase
    end
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle();
    req = 0; we = 0; step();
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    req = 1; we = 1; addr = AW'(a); wdata = d; step(); req = 0; we = 0;
  endtask

  task automatic rd(input int a);
    req = 1; we = 0; addr = AW'(a); step(); req = 0;
  endtask

  initial begin
    #(8 * 150000);
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    model_reset();
    in_reset_phase = 1;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1: reset image of every mapped word
    for (int a = 0; a < 'h80; a += 4) rd(a);
    in_reset_phase = 0;

    // R11: plain registers
    wr('h00, 32'hDEAD_0007); wr('h04, 32'h3); wr('h28, 32'h0012_0034);
    wr('h2C, 32'hA5A5_5A5A); wr('h40, 32'h0000_0085); wr('h1C, 32'hFFFF_FFFC);
    rd('h00); rd('h04); rd('h28); rd('h2C); rd('h40); rd('h1C);

    // R9: chip-select checks
    wr('h10, 2); rd('h10); wr('h10, 1); rd('h10); wr('h10, 32'h8000_0001); rd('h10);
    wr('h14, 4); rd('h14); wr('h14, 1); rd('h14); wr('h14, 0); rd('h14);
    wr('h18, 4); rd('h18); wr('h18, 3); rd('h18); wr('h18, 2); rd('h18);

    // R8: watermarks
    wr('h50, 8); rd('h50); wr('h50, 32'hFFFF_FFFF); rd('h50);
    wr('h50, 5); rd('h50); wr('h54, 9); rd('h54); wr('h54, 2); rd('h54);
    wr('h70, 3); rd('h74);

    // R2/R3: fill TX with engine stalled, ninth write dropped
    for (int i = 0; i < 9; i++) begin wr('h48, 32'hFFFF_FF00 | i * 17); rd('h48); rd('h74); end
    rd('h48);
    // R2: drain while pushing in the same cycle the head leaves
    txr = 1;
    wr('h48, 32'h0000_00C3);
    for (int i = 0; i < 4; i++) idle();
    // R5: engine returns bytes, one-cycle delay, no reads
    for (int i = 0; i < 10; i++) begin rxd = 1; rxb = 8'(8'h30 + i); idle(); end
    rxd = 0; txr = 0;
    idle(); idle();
    rd('h74);
    // R4/R5: pop full RX in the cycle a delayed byte lands
    rxd = 1; rxb = 8'h77; idle(); rxd = 0;
    rd('h4C);
    rxd = 1; rxb = 8'h78; rd('h4C); rxd = 0;
    for (int i = 0; i < 10; i++) rd('h4C);
    // R5: discard when frame format bit 3 set
    wr('h40, 32'h0000_0008);
    rxd = 1; rxb = 8'h99; idle(); rxd = 0; idle();
    rd('h4C);
    wr('h40, 32'h0);
    rxd = 1; rxb = 8'h5A; idle(); rxd = 0; idle();
    rd('h74); rd('h4C); rd('h4C);

    // R10: reserved, unmapped and read-only targets
    wr('h08, 32'h1234); rd('h08); wr('h20, 32'h1); rd('h20); wr('h44, 32'h5); rd('h44);
    wr('h60, 32'h7); rd('h60); wr('h64, 32'h7); rd('h64);
    wr('h4C, 32'h0000_00EE); rd('h4C);
    wr('h74, 32'h3); rd('h74);
    wr('h400, 32'hFFFF_FFFF); rd('h400); rd('h000);

    // R6/R7: enable mask variants
    wr('h54, 0); wr('h50, 7);
    rxd = 1; rxb = 8'h11; idle(); rxd = 0; idle();
    wr('h70, 1); rd('h74); wr('h70, 2); rd('h74); wr('h70, 0); rd('h74);
    rd('h4C); rd('h74);
    txr = 1; for (int i = 0; i < 10; i++) idle(); txr = 0;

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule